// File: doc/BRIEF.md
# Bus Suspend Detector With Interrupt

This block sits beside a USB serial engine and decides whether the bus is idle enough to count as suspended. It watches start-of-frame (SOF) pulses against a 1 ms tick. Each tick that passes without an SOF counts as one missed frame. When three frames in a row are missed, the link is declared suspended. Any bus activity or a fresh SOF brings it back to awake.

Every move between awake and suspended sets a sticky change bit, and that bit drives an interrupt line to the CPU. The CPU reads its interrupt register, which the block sees as a one-cycle read-to-clear strobe. That strobe drops the change bit. A mode input adds an SOF interrupt source. While it is high, every received SOF latches a pending source that also drives the interrupt line.

The control is a two-state machine. Its states are AWAKE and SUSPENDED. The ENTER transition goes from AWAKE to SUSPENDED. It is taken when the missed-frame counter sits at its limit and no SOF arrives in that cycle. The RESUME transition goes from SUSPENDED to AWAKE. It is taken on an activity pulse or on an SOF.

Top module: `bus_sleep_watch`

## Requirements
- R1: After reset, `suspended`, `change_flag` and `irq` are all low, and the missed-frame counter is zero.
- R2: An SOF pulse returns the missed-frame counter to zero. If an SOF arrives in every interval, the block never reaches SUSPENDED, however many ticks pass.
- R3: `suspended` rises at the clock edge that follows the edge which registers the third consecutive SOF-less tick. If an SOF arrives in that following cycle, the link stays awake.
- R4: When an SOF and a tick arrive in the same cycle, the SOF wins and the counter goes to zero.
- R5: While the link is SUSPENDED, an activity pulse or an SOF returns it to AWAKE at the next edge. The counter restarts from zero, so three further missed ticks are needed to suspend again.
- R6: An activity pulse while the link is AWAKE has no effect. Missed ticks before and after it still add up toward suspend.
- R7: Both the ENTER and the RESUME transition set `change_flag` and `irq` at the same edge that changes `suspended`.
- R8: `change_flag` stays high until a read-to-clear strobe, which clears it at the next edge. `irq` then falls if no SOF source is pending.
- R9: If a transition and a read-to-clear strobe land in the same cycle, the set wins and `change_flag` stays high.
- R10: With `sof_irq_mode` high, each SOF sets a pending source that holds `irq` high until a read-to-clear strobe. With the mode low, an SOF never raises `irq`.
- R11: The counter saturates at three. Further ticks while the link is SUSPENDED cause no new transition and do not set `change_flag` again once it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_irq_mode | input | 1 | 1 = each SOF also raises the interrupt |
| sof_pulse | input | 1 | One-cycle pulse per received SOF |
| activity_pulse | input | 1 | One-cycle pulse on any bus activity |
| ms_tick | input | 1 | One-cycle pulse each 1 ms frame interval |
| rd_clear | input | 1 | CPU read of the interrupt register (clears sources) |
| suspended | output | 1 | 1 while the link is SUSPENDED |
| change_flag | output | 1 | Sticky bit, set by ENTER or RESUME |
| irq | output | 1 | Interrupt request, high while any source is pending |

## Verification
The bench goes after the counting edges. The first is two missed ticks followed by an SOF. A design that does not clear its count on SOF would suspend early. The second is an SOF landing on the same cycle as a tick, where a design that gives the tick priority would drift toward suspend. The third is an SOF in the cycle just before ENTER, where a design that ignores it would suspend a live bus.

The bench also checks that an activity pulse while awake is ignored. A design that cleared the count on it would never suspend. After RESUME it checks that three fresh ticks are required, which catches a counter that keeps its stale value and re-suspends at once.

On the interrupt side, the bench issues a clear in the same cycle as a transition. A design that let the clear win would lose the event. The bench also checks that SOFs raise `irq` only in SOF mode.

// File: rtl/sleep_watch_pkg.sv
package sleep_watch_pkg;
    typedef enum logic [0:0] {
        LINK_AWAKE     = 1'b0,
        LINK_SUSPENDED = 1'b1
    } link_state_t;
endpackage

// File: rtl/miss_counter.sv
module miss_counter #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_pulse,
    input  logic restart,
    input  logic ms_tick,
    output logic at_limit
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sof_pulse || restart) begin
            cnt_q <= '0;
        end else if (ms_tick && (cnt_q < LIM_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == LIM_V);

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_V);
    // R4
    sof_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> (cnt_q == '0));
endmodule

// File: rtl/link_state_fsm.sv
module link_state_fsm
    import sleep_watch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic at_limit,
    input  logic sof_pulse,
    input  logic activity_pulse,
    output logic suspended,
    output logic restart,
    output logic trans_evt
);
    link_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINK_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_AWAKE:     if (at_limit && !sof_pulse) state_d = LINK_SUSPENDED;
            LINK_SUSPENDED: if (activity_pulse || sof_pulse) state_d = LINK_AWAKE;
            default:        state_d = LINK_AWAKE;
        endcase
    end

    always_comb begin
        suspended = (state_q == LINK_SUSPENDED);
        restart   = (state_q == LINK_SUSPENDED) && activity_pulse;
        trans_evt = (state_d != state_q);
    end

    // R3
    enter_needs_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(at_limit));
    // R5
    resume_on_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && (activity_pulse || sof_pulse)) |=> !suspended);
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trans_evt,
    input  logic sof_pulse,
    input  logic sof_irq_mode,
    input  logic rd_clear,
    output logic change_flag,
    output logic irq
);
    logic change_q, pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            change_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (trans_evt)     change_q <= 1'b1;
            else if (rd_clear) change_q <= 1'b0;
            if (sof_pulse && sof_irq_mode) pend_q <= 1'b1;
            else if (rd_clear)             pend_q <= 1'b0;
        end
    end

    assign change_flag = change_q;
    assign irq         = change_q | pend_q;

    // R7
    change_on_trans_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trans_evt |=> (change_flag && irq));
    // R8
    clear_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !trans_evt && !(sof_pulse && sof_irq_mode)) |=> !irq);
endmodule

// File: rtl/bus_sleep_watch.sv
module bus_sleep_watch #(
    parameter int MISS_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_irq_mode,
    input  logic sof_pulse,
    input  logic activity_pulse,
    input  logic ms_tick,
    input  logic rd_clear,
    output logic suspended,
    output logic change_flag,
    output logic irq
);
    logic at_limit, restart, trans_evt;

    miss_counter #(.LIMIT(MISS_LIMIT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sof_pulse(sof_pulse),
        .restart(restart), .ms_tick(ms_tick), .at_limit(at_limit)
    );

    link_state_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .at_limit(at_limit), .sof_pulse(sof_pulse),
        .activity_pulse(activity_pulse), .suspended(suspended),
        .restart(restart), .trans_evt(trans_evt)
    );

    irq_latch u_irq (
        .clk(clk), .rst_n(rst_n), .trans_evt(trans_evt), .sof_pulse(sof_pulse),
        .sof_irq_mode(sof_irq_mode), .rd_clear(rd_clear),
        .change_flag(change_flag), .irq(irq)
    );

    // R10
    no_sof_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !sof_irq_mode && !trans_evt) |=> !irq);
endmodule

// File: tb/bus_sleep_watch_tb.sv
module bus_sleep_watch_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode = 1'b0, sof = 1'b0, act = 1'b0, tick = 1'b0, rdc = 1'b0;
    logic suspended, change_flag, irq;

    int checks = 0, errors = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    // reference state, kept from the requirements
    logic m_susp = 1'b0, m_chg = 1'b0, m_pend = 1'b0;
    int   m_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_sleep_watch u_dut (
        .clk(clk), .rst_n(rst_n), .sof_irq_mode(mode), .sof_pulse(sof),
        .activity_pulse(act), .ms_tick(tick), .rd_clear(rdc),
        .suspended(suspended), .change_flag(change_flag), .irq(irq)
    );

    task automatic step(input logic s, input logic a, input logic t,
                        input logic r, input string tag);
        logic nsusp, trans;
        @(negedge clk);
        sof = s; act = a; tick = t; rdc = r;
        nsusp = m_susp;
        if (!m_susp && m_cnt == 3 && !s) nsusp = 1'b1;
        if (m_susp && (a || s))          nsusp = 1'b0;
        trans = (nsusp != m_susp);
        if (s)                   m_cnt = 0;
        else if (m_susp && a)    m_cnt = 0;
        else if (t && m_cnt < 3) m_cnt = m_cnt + 1;
        m_susp = nsusp;
        if (trans)  m_chg = 1'b1; else if (r) m_chg = 1'b0;
        if (s && mode) m_pend = 1'b1; else if (r) m_pend = 1'b0;
        exp_q.push_back({m_susp, m_chg, m_chg | m_pend});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
    endtask

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if ({suspended, change_flag, irq} !== e) begin
                errors++;
                $display("FAIL %s: {susp,chg,irq} actual %b expected %b",
                         tg, {suspended, change_flag, irq}, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({suspended, change_flag, irq} !== 3'b000) begin
            errors++;
            $display("FAIL R1: actual %b expected 000", {suspended, change_flag, irq});
        end
        idle(2, "R1");
        // R2: SOF every interval keeps the link awake
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 1, 0, "R2");
            step(1, 0, 0, 0, "R2");
        end
        // R2: two misses, SOF, two misses -> still awake
        step(0, 0, 1, 0, "R2"); step(0, 0, 1, 0, "R2");
        step(1, 0, 0, 0, "R2");
        step(0, 0, 1, 0, "R2"); step(0, 0, 1, 0, "R2");
        // R3: third miss, suspend one edge later
        step(0, 0, 1, 0, "R3");
        step(0, 0, 0, 0, "R3");
        idle(2, "R7");
        // R11: ticks while suspended
        step(0, 0, 0, 1, "R8");
        step(0, 0, 1, 0, "R11"); step(0, 0, 1, 0, "R11");
        idle(2, "R11");
        // R5: activity resumes, fresh three ticks required
        step(0, 1, 0, 0, "R5");
        step(0, 0, 0, 1, "R8");
        step(0, 0, 1, 0, "R5"); step(0, 0, 1, 0, "R5");
        idle(2, "R5");
        // R6: activity while awake ignored
        step(0, 1, 0, 0, "R6");
        step(0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, "R6");
        idle(2, "R6");
        // R5: SOF resumes from suspend, with clear in same cycle as transition (R9)
        step(1, 0, 0, 1, "R9");
        idle(2, "R9");
        step(0, 0, 0, 1, "R8");
        idle(1, "R8");
        // R4: SOF and tick together
        step(0, 0, 1, 0, "R4"); step(0, 0, 1, 0, "R4");
        step(1, 0, 1, 0, "R4");
        step(0, 0, 1, 0, "R4"); step(0, 0, 1, 0, "R4");
        idle(2, "R4");
        // R3: SOF in the cycle before ENTER blocks it
        step(1, 0, 0, 0, "R3");
        step(0, 0, 1, 0, "R3"); step(0, 0, 1, 0, "R3"); step(0, 0, 1, 0, "R3");
        step(1, 0, 0, 0, "R3");
        idle(2, "R3");
        // R10: SOF mode off then on
        step(1, 0, 0, 0, "R10"); idle(1, "R10");
        mode = 1'b1;
        step(1, 0, 0, 0, "R10"); idle(2, "R10");
        step(0, 0, 0, 1, "R10"); idle(1, "R10");
        step(1, 0, 0, 1, "R10"); idle(1, "R10");
        mode = 1'b0;
        step(0, 0, 0, 1, "R10"); idle(2, "R10");
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule